// File: doc/BRIEF.md
# Bus Mode Detect and Debounce Controller

This controller picks the operating mode of a multimode bus terminator. Two comparator flags describe the sensed mode line: one says the level is above the low threshold and one says it is above the high threshold. From these flags the controller decodes a candidate mode: single-ended, low-voltage differential or high-power differential. It adopts that candidate only after a long qualification delay, and the delay is built to tolerate noise on the sense line. After reset the adopted mode is high-power differential.

The adopted mode drives three one-hot status outputs. It also drives the enables for the line switches, the regulator setpoint select and the sense-line driver. A disconnect input turns the termination, the regulator and the sense-line driver off. Detection, qualification and status carry on while disconnected. A master select input decides whether this instance drives the sense line. The qualification uses a saturating up/down counter. The `QUAL_TICKS` parameter sets its terminal value; the default is 180 ms at 200 MHz.

Top module: `bus_mode_ctrl`

## Requirements
- R1: Decoding of the comparator flags: `above_hi`=1 decodes as high-power differential. `above_hi`=0 with `above_lo`=1 decodes as low-voltage differential. Both flags 0 decode as single-ended.
- R2: During reset and in the first cycle after it, the adopted mode is high-power differential, whatever the flags show. The status outputs then read `st_hpd`=1, `st_lvd`=0 and `st_se`=0.
- R3: A decoded mode that differs from the adopted mode, held steady, is adopted at the QUAL_TICKS-th rising clock edge of the qualification and not before.
- R4: The qualification length is the same for every transition between any pair of modes.
- R5: Noise tolerance: while qualifying, each cycle whose decoded mode differs from the candidate lowers the count by one instead of restarting it. For example, with QUAL_TICKS=16, 8 matching cycles, then 2 mismatching cycles, then a steady match commits on the 10th matching cycle.
- R6: Exactly one of `st_se`, `st_lvd` and `st_hpd` is high, and it names the adopted mode.
- R7: In single-ended mode, while connected, `pos_gnd_en`=1, `neg_reg_en`=1, `diff_net_en`=0 and `reg_sel_hi`=1 (1 selects the 2.7 V setpoint).
- R8: In low-voltage differential mode, while connected, `diff_net_en`=1, `pos_gnd_en`=0, `neg_reg_en`=0 and `reg_sel_hi`=0 (the 1.25 V setpoint).
- R9: In high-power differential mode, all three line enables are 0 and `reg_sel_hi`=0.
- R10: While `disconnect`=1, the outputs `pos_gnd_en`, `neg_reg_en`, `diff_net_en`, `reg_on` and `sense_drv_en` are all 0. Decoding, qualification and the status outputs go on unchanged. `reg_on`=1 whenever connected.
- R11: `sense_drv_en` is 1 exactly when `disconnect`=0 and `master_sel`=1.
- R12: A new candidate is latched only when the count is zero. When the decoded mode matches the adopted mode and the count is zero, nothing counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| above_lo | input | 1 | Sense level above the low threshold |
| above_hi | input | 1 | Sense level above the high threshold |
| disconnect | input | 1 | 1 turns termination, regulator and sense driver off |
| master_sel | input | 1 | 1 lets this instance drive the sense line |
| st_se | output | 1 | Single-ended mode status |
| st_lvd | output | 1 | Low-voltage differential mode status |
| st_hpd | output | 1 | High-power differential mode status |
| pos_gnd_en | output | 1 | Positive lines switched to ground |
| neg_reg_en | output | 1 | Negative lines tied to the regulator through the single-ended network |
| diff_net_en | output | 1 | Differential termination network enabled |
| reg_on | output | 1 | Termination regulator enabled |
| reg_sel_hi | output | 1 | Regulator setpoint: 1 = 2.7 V, 0 = 1.25 V |
| sense_drv_en | output | 1 | Sense-line driver enabled |

## Verification
The bench targets the commit edge. A counter that is off by one adopts the mode a cycle early or a cycle late, and the cycle-exact comparison catches it. Short glitches in the middle of a qualification are checked next. A design that restarts the count would commit too late, and one that swaps the candidate while the count is nonzero would commit to the wrong mode. Disconnect is toggled while a change is qualifying: a design that freezes detection while disconnected stalls the change, and one that forgets the master-select gating drives the sense line when it should not.

// File: rtl/bus_mode_ctrl.sv
module bus_mode_ctrl #(
  parameter int unsigned QUAL_TICKS = 36_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above_lo,
  input  logic above_hi,
  input  logic disconnect,
  input  logic master_sel,
  output logic st_se,
  output logic st_lvd,
  output logic st_hpd,
  output logic pos_gnd_en,
  output logic neg_reg_en,
  output logic diff_net_en,
  output logic reg_on,
  output logic reg_sel_hi,
  output logic sense_drv_en
);
  localparam int CW = $clog2(QUAL_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_TICKS - 1);
  localparam logic [1:0] M_SE = 2'd0, M_LVD = 2'd1, M_HPD = 2'd2;

  logic [1:0]    mode, cand, dec;
  logic [CW-1:0] cnt;

  assign dec = above_hi ? M_HPD : (above_lo ? M_LVD : M_SE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_HPD;
      cand <= M_HPD;
      cnt  <= '0;
    end else if (cnt == '0) begin
      cand <= dec;
      if (dec != mode) cnt <= CW'(1);
    end else if (dec == cand) begin
      if (cnt == LAST) begin
        mode <= cand;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign st_se  = (mode == M_SE);
  assign st_lvd = (mode == M_LVD);
  assign st_hpd = (mode == M_HPD);

  assign reg_on       = !disconnect;
  assign pos_gnd_en   = reg_on && st_se;
  assign neg_reg_en   = reg_on && st_se;
  assign diff_net_en  = reg_on && st_lvd;
  assign reg_sel_hi   = st_se;
  assign sense_drv_en = reg_on && master_sel;

  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({st_se, st_lvd, st_hpd}));

  a_r3_commit_at_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> ($past(cnt) == LAST && cnt == '0));

  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |->
      (cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1 || cnt == '0));

  a_r12_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  a_r10_disc_off: assert property (@(posedge clk) disable iff (!rst_n)
    disconnect |-> !(pos_gnd_en || neg_reg_en || diff_net_en || reg_on || sense_drv_en));

  a_r11_sense_gate: assert property (@(posedge clk) disable iff (!rst_n)
    sense_drv_en |-> (master_sel && !disconnect));
endmodule

// File: tb/tb_bus_mode_ctrl.sv
module tb_bus_mode_ctrl;
  localparam int Q = 16;
  logic clk = 0, rst_n = 0;
  logic above_lo = 0, above_hi = 0, disconnect = 0, master_sel = 0;
  logic st_se, st_lvd, st_hpd, pos_gnd_en, neg_reg_en, diff_net_en, reg_on, reg_sel_hi, sense_drv_en;
  int errors = 0, checks = 0, cycles = 0;
  logic [1:0] m_mode = 2, m_cand = 2;
  int m_cnt = 0;

  bus_mode_ctrl #(.QUAL_TICKS(Q)) dut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [1:0] decode(logic lo, logic hi);
    return hi ? 2'd2 : (lo ? 2'd1 : 2'd0);
  endfunction

  function automatic logic [8:0] expect_out(logic [1:0] md, logic dsc, logic ms);
    logic con = !dsc;
    return {md == 2'd0, md == 2'd1, md == 2'd2,
            con && md == 2'd0, con && md == 2'd0, con && md == 2'd1,
            con, md == 2'd0, con && ms};
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      m_mode <= 2; m_cand <= 2; m_cnt <= 0;
    end else if (m_cnt == 0) begin
      m_cand <= decode(above_lo, above_hi);
      if (decode(above_lo, above_hi) != m_mode) m_cnt <= 1;
    end else if (decode(above_lo, above_hi) == m_cand) begin
      if (m_cnt == Q - 1) begin m_mode <= m_cand; m_cnt <= 0; end
      else m_cnt <= m_cnt + 1;
    end else m_cnt <= m_cnt - 1;
  end

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] outs();
    return {st_se, st_lvd, st_hpd, pos_gnd_en, neg_reg_en, diff_net_en, reg_on, reg_sel_hi, sense_drv_en};
  endfunction

  task automatic step(logic lo, logic hi, logic dsc, logic ms, string tag);
    above_lo = lo; above_hi = hi; disconnect = dsc; master_sel = ms;
    @(negedge clk);
    check(tag, outs(), expect_out(m_mode, disconnect, master_sel));
  endtask

  task automatic hold(int n, logic lo, logic hi, string tag);
    for (int i = 0; i < n; i++) step(lo, hi, 0, 1, tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R2 reset", outs(), expect_out(2'd2, 0, 0));
    rst_n = 1;
    step(1, 1, 0, 1, "R2 first cycle");
    check("R2 hpd status", {st_se, st_lvd, st_hpd}, 3'b001);
    hold(Q - 1, 1, 0, "R3 qualify lvd");
    check("R3 not early", {st_se, st_lvd, st_hpd}, 3'b001);
    step(1, 0, 0, 1, "R3 commit");
    check("R1 R8 lvd outputs", outs(), 9'b010_001_101);
    hold(Q - 1, 0, 0, "R4 qualify se");
    check("R4 not early", {st_se, st_lvd, st_hpd}, 3'b010);
    step(0, 0, 0, 0, "R4 commit");
    check("R1 R7 se outputs", outs(), 9'b100_110_110);
    hold(Q, 0, 0, "R12 idle same mode");
    check("R12 stays se", {st_se, st_lvd, st_hpd}, 3'b100);
    hold(8, 1, 0, "R5 pre-glitch");
    hold(2, 0, 0, "R5 glitch");
    hold(9, 1, 0, "R5 resume");
    check("R5 not yet", {st_se, st_lvd, st_hpd}, 3'b100);
    step(1, 0, 0, 1, "R5 commit");
    check("R5 committed", {st_se, st_lvd, st_hpd}, 3'b010);
    for (int i = 0; i < Q; i++) step(1, 1, 1, 1, "R10 qualify while disconnected");
    check("R10 R9 hpd disconnected", outs(), 9'b001_000_000);
    step(1, 1, 0, 0, "R9 R11 hpd connected no master");
    check("R9 hpd outputs", outs(), 9'b001_000_100);
    begin
      logic lo = 0, hi = 0;
      for (int i = 0; i < 6000; i++) begin
        if ($urandom_range(0, 19) == 0) begin lo = $urandom_range(0, 1); hi = $urandom_range(0, 1); end
        if ($urandom_range(0, 9) == 0) step(!lo, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), "R1 R5 R6 R10 R11 random");
        else step(lo, hi, $urandom_range(0, 3) == 0, $urandom_range(0, 1), "R1 R3 R4 R6 R11 random");
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule